// File: doc/BRIEF.md
# PI Clock Offset Servo

This block runs once per synchronization period on a slave node of a ring network. It turns the time error between the master and the slave into a signed frequency correction for the slave clock's addend register. It starts with one timestamp exchange around the ring. From the master send time, the slave's two pass times and the master return time, it derives the one-way link delay and the initial offset. It holds both values from then on.

After that, each sync event supplies a master reference time and the slave's local receive time. The block forms the error as reference time plus one-way delay minus local time. In PI mode it runs a discrete proportional-integral law with programmable signed Q4.12 gains. In relay mode it instead issues a fixed step whose sign follows the sign of the error, so that the two laws can be compared. Each correction appears with a one-cycle valid strobe in the cycle after the sync sample.

Top module: `pi_clock_servo`

## Requirements
- R1: After reset `corr_valid_o`, `corr_o`, `lock_o`, `delay_o` and `offset_o` are all zero.
- R2: When `meas_valid_i` is sampled while `lock_o` is low, the block sets `lock_o` in the next cycle. In the same cycle it shows `delay_o` = ((T4−T1)−(T3−T2)) arithmetically shifted right by one and `offset_o` = T2−T1−delay. All values are signed 64-bit nanoseconds.
- R3: While `lock_o` is high, `meas_valid_i` is ignored and `delay_o`/`offset_o` keep their values.
- R4: A sampled `measure_req_i` clears `lock_o` and the integrator. It takes priority over `meas_valid_i` and `sync_valid_i` in the same cycle, and it leaves `delay_o`/`offset_o` unchanged until the next measurement.
- R5: A sync sample taken while unlocked produces no correction and no strobe.
- R6: The error is master time + `delay_o` − local time, as a signed 64-bit value.
- R7: In PI mode the integrator first adds the error. The block then outputs P·error + I·integrator, where P and I are signed Q4.12 and `corr_o` is in Q.12 units (4096 = 1.0). The result saturates to the 48-bit signed range.
- R8: The 48-bit signed integrator saturates at −2^47 and 2^47−1 and never wraps.
- R9: In relay mode the correction is +410 (0.1 in Q.12) for a positive error, −410 for a negative error and 0 for a zero error. The integrator holds its value.
- R10: `corr_valid_o` is high for exactly one cycle, the cycle after each locked sync sample. `corr_o` holds between strobes.
- R11: Any gain value is accepted and applied as written, including P = 2.5 (0x2800) with I = 1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| relay_mode_i | input | 1 | 1 selects the fixed-step relay law, 0 selects PI |
| kp_i | input | 16 | Proportional gain, signed Q4.12 |
| ki_i | input | 16 | Integral gain, signed Q4.12 |
| measure_req_i | input | 1 | Restart the delay/offset measurement |
| meas_valid_i | input | 1 | Ring timestamps t1..t4 are valid |
| t1_i | input | 64 | Master send time |
| t2_i | input | 64 | Slave first-pass receive time |
| t3_i | input | 64 | Slave return-pass receive time |
| t4_i | input | 64 | Master receive time |
| sync_valid_i | input | 1 | Sync sample strobe |
| master_time_i | input | 64 | Master reference time of the sync event |
| local_time_i | input | 64 | Slave local receive time of the sync event |
| corr_valid_o | output | 1 | New correction strobe |
| corr_o | output | 48 | Signed frequency correction, Q.12 |
| lock_o | output | 1 | Delay and offset measured and held |
| delay_o | output | 64 | One-way link delay |
| offset_o | output | 64 | Initial slave-minus-master offset |

## Verification
A restart request can fall in the same cycle as a sync sample. A restart request can also fall in the same cycle as a new timestamp set. The bench raises `measure_req_i` together with `sync_valid_i` while locked. It then judges that no strobe follows, that the lock drops and that the held delay survives. After a new measurement, a sync with zero error and a pure integral gain shows that the integrator restarted at zero.

// File: rtl/pics_pkg.sv
package pics_pkg;
  localparam int TS_W      = 64;
  localparam int ACC_W     = 48;
  localparam int GAIN_W    = 16;
  localparam int CORR_W    = 48;
  localparam int GAIN_FRAC = 12;
  // 0.1 in Q.12, rounded
  localparam int RELAY_STEP = (4096 + 5) / 10;

  typedef enum logic {LAW_PI = 1'b0, LAW_RELAY = 1'b1} law_e;
endpackage

// File: rtl/pics_link_meas.sv
module pics_link_meas #(
  parameter int TS_W = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   meas_valid_i,
  input  logic signed [TS_W-1:0] t1_i,
  input  logic signed [TS_W-1:0] t2_i,
  input  logic signed [TS_W-1:0] t3_i,
  input  logic signed [TS_W-1:0] t4_i,
  output logic                   lock_o,
  output logic signed [TS_W-1:0] delay_o,
  output logic signed [TS_W-1:0] offset_o
);
  logic signed [TS_W-1:0] round_trip, residence, dly_c, off_c;

  always_comb begin
    round_trip = t4_i - t1_i;
    residence  = t3_i - t2_i;
    dly_c      = (round_trip - residence) >>> 1;
    off_c      = t2_i - t1_i - dly_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o   <= 1'b0;
      delay_o  <= '0;
      offset_o <= '0;
    end else if (req_i) begin
      lock_o <= 1'b0;
    end else if (meas_valid_i && !lock_o) begin
      lock_o   <= 1'b1;
      delay_o  <= dly_c;
      offset_o <= off_c;
    end
  end

  // R2
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($past(meas_valid_i) && !$past(req_i)));
  // R3
  delay_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_o) |-> ($stable(delay_o) && $stable(offset_o)));
endmodule

// File: rtl/pics_integrator.sv
module pics_integrator #(
  parameter int TS_W  = 64,
  parameter int ACC_W = 48
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic signed [TS_W-1:0]  err_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic signed [ACC_W-1:0] acc_next_o
);
  localparam int SW = TS_W + 1;

  logic signed [SW-1:0] sum;
  logic                 ovf;

  always_comb begin
    sum = {{(SW-ACC_W){acc_o[ACC_W-1]}}, acc_o} + {err_i[TS_W-1], err_i};
    ovf = !((&sum[SW-1:ACC_W-1]) || !(|sum[SW-1:ACC_W-1]));
    if (ovf) acc_next_o = sum[SW-1] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    else     acc_next_o = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (en_i)  acc_o <= acc_next_o;
  end

  // R9
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_i) && !$past(clr_i)) |-> $stable(acc_o));
  // R8
  acc_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(clr_i) && ($past(err_i) >= 0) && ($past(acc_o) >= 0)) |-> (acc_o >= 0));
endmodule

// File: rtl/pics_law.sv
module pics_law #(
  parameter int TS_W       = 64,
  parameter int ACC_W      = 48,
  parameter int GAIN_W     = 16,
  parameter int CORR_W     = 48,
  parameter int RELAY_STEP = 410
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fire_i,
  input  pics_pkg::law_e           law_i,
  input  logic signed [TS_W-1:0]   err_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  input  logic signed [GAIN_W-1:0] kp_i,
  input  logic signed [GAIN_W-1:0] ki_i,
  output logic                     valid_o,
  output logic signed [CORR_W-1:0] corr_o
);
  localparam int PW = TS_W + GAIN_W;
  localparam int SW = PW + 1;
  localparam logic signed [CORR_W-1:0] STEP = CORR_W'(RELAY_STEP);

  logic signed [PW-1:0]     p_term, i_term;
  logic signed [SW-1:0]     sum;
  logic                     ovf;
  logic signed [CORR_W-1:0] pi_c, relay_c, corr_c;

  always_comb begin
    p_term = {{(PW-TS_W){err_i[TS_W-1]}}, err_i} * {{(PW-GAIN_W){kp_i[GAIN_W-1]}}, kp_i};
    i_term = {{(PW-ACC_W){acc_i[ACC_W-1]}}, acc_i} * {{(PW-GAIN_W){ki_i[GAIN_W-1]}}, ki_i};
    sum    = {p_term[PW-1], p_term} + {i_term[PW-1], i_term};
    ovf    = !((&sum[SW-1:CORR_W-1]) || !(|sum[SW-1:CORR_W-1]));
    if (ovf) pi_c = sum[SW-1] ? {1'b1, {(CORR_W-1){1'b0}}} : {1'b0, {(CORR_W-1){1'b1}}};
    else     pi_c = sum[CORR_W-1:0];
    if (err_i > 0)      relay_c = STEP;
    else if (err_i < 0) relay_c = -STEP;
    else                relay_c = '0;
    corr_c = (law_i == pics_pkg::LAW_RELAY) ? relay_c : pi_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      corr_o  <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) corr_o <= corr_c;
    end
  end

  // R10
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(fire_i));
  // R10
  corr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fire_i) |-> $stable(corr_o));
  // R9
  relay_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(law_i == pics_pkg::LAW_RELAY)) |-> (corr_o == STEP || corr_o == -STEP || corr_o == '0));
endmodule

// File: rtl/pi_clock_servo.sv
module pi_clock_servo
  import pics_pkg::*;
#(
  parameter int P_TS_W   = TS_W,
  parameter int P_ACC_W  = ACC_W,
  parameter int P_GAIN_W = GAIN_W,
  parameter int P_CORR_W = CORR_W,
  parameter int P_STEP   = RELAY_STEP
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       relay_mode_i,
  input  logic signed [P_GAIN_W-1:0] kp_i,
  input  logic signed [P_GAIN_W-1:0] ki_i,
  input  logic                       measure_req_i,
  input  logic                       meas_valid_i,
  input  logic signed [P_TS_W-1:0]   t1_i,
  input  logic signed [P_TS_W-1:0]   t2_i,
  input  logic signed [P_TS_W-1:0]   t3_i,
  input  logic signed [P_TS_W-1:0]   t4_i,
  input  logic                       sync_valid_i,
  input  logic signed [P_TS_W-1:0]   master_time_i,
  input  logic signed [P_TS_W-1:0]   local_time_i,
  output logic                       corr_valid_o,
  output logic signed [P_CORR_W-1:0] corr_o,
  output logic                       lock_o,
  output logic signed [P_TS_W-1:0]   delay_o,
  output logic signed [P_TS_W-1:0]   offset_o
);
  law_e                      law;
  logic                      fire;
  logic signed [P_TS_W-1:0]  err;
  logic signed [P_ACC_W-1:0] acc, acc_next;

  assign law  = relay_mode_i ? LAW_RELAY : LAW_PI;
  assign fire = sync_valid_i && lock_o && !measure_req_i;
  assign err  = master_time_i + delay_o - local_time_i;

  pics_link_meas #(.TS_W(P_TS_W)) u_meas (
    .clk_i, .rst_ni,
    .req_i        (measure_req_i),
    .meas_valid_i,
    .t1_i, .t2_i, .t3_i, .t4_i,
    .lock_o, .delay_o, .offset_o
  );

  pics_integrator #(.TS_W(P_TS_W), .ACC_W(P_ACC_W)) u_int (
    .clk_i, .rst_ni,
    .clr_i      (measure_req_i),
    .en_i       (fire && law == LAW_PI),
    .err_i      (err),
    .acc_o      (acc),
    .acc_next_o (acc_next)
  );

  pics_law #(
    .TS_W(P_TS_W), .ACC_W(P_ACC_W), .GAIN_W(P_GAIN_W),
    .CORR_W(P_CORR_W), .RELAY_STEP(P_STEP)
  ) u_law (
    .clk_i, .rst_ni,
    .fire_i  (fire),
    .law_i   (law),
    .err_i   (err),
    .acc_i   (acc_next),
    .kp_i, .ki_i,
    .valid_o (corr_valid_o),
    .corr_o
  );

  // R5
  no_unlocked_corr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |-> $past(lock_o));
  // R4
  req_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(measure_req_i) |-> (!lock_o && !corr_valid_o));
endmodule

// File: tb/pi_clock_servo_tb.sv
module pi_clock_servo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        relay = 1'b0;
  logic [15:0] kp = 16'h1000, ki = 16'h1000;
  logic        mreq = 1'b0, mval = 1'b0, sval = 1'b0;
  logic [63:0] t1 = '0, t2 = '0, t3 = '0, t4 = '0, mt = '0, lt = '0;
  logic        cval, lock;
  logic [47:0] corr;
  logic [63:0] dly, off;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pi_clock_servo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .relay_mode_i(relay), .kp_i(kp), .ki_i(ki),
    .measure_req_i(mreq), .meas_valid_i(mval),
    .t1_i(t1), .t2_i(t2), .t3_i(t3), .t4_i(t4),
    .sync_valid_i(sval), .master_time_i(mt), .local_time_i(lt),
    .corr_valid_o(cval), .corr_o(corr), .lock_o(lock), .delay_o(dly), .offset_o(off)
  );

  // master, local, expected correction; P = I = 1.0, delay 650
  localparam longint VEC [4][3] = '{
    '{10000, 10600,  409600},
    '{20000, 20660,  122880},
    '{30000, 30650,  163840},
    '{40000, 40700, -245760}
  };
  localparam longint CMAX = 64'sd140737488355327;
  localparam longint CMIN = -64'sd140737488355328;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sc(logic [47:0] v);
    return longint'($signed(v));
  endfunction

  task automatic do_sync(longint m, longint l);
    @(negedge clk); sval = 1'b1; mt = m; lt = l;
    @(negedge clk); sval = 1'b0;
  endtask

  task automatic do_meas(longint a, longint b, longint c, longint d);
    @(negedge clk); mval = 1'b1; t1 = a; t2 = b; t3 = c; t4 = d;
    @(negedge clk); mval = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", cval, 0); chk("R1 corr", sc(corr), 0); chk("R1 lock", lock, 0);
    chk("R1 delay", dly, 0); chk("R1 offset", off, 0);
    rst_n = 1'b1;
    // R5
    do_sync(5000, 1000);
    chk("R5 no strobe unlocked", cval, 0);
    // R2
    do_meas(1000, 1700, 2600, 3200);
    chk("R2 lock", lock, 1); chk("R2 delay", dly, 650); chk("R2 offset", off, 50);
    // R3
    do_meas(0, 9000, 9100, 90000);
    chk("R3 delay held", dly, 650); chk("R3 offset held", off, 50);
    // R6 R7 R10 table
    for (int i = 0; i < 4; i++) begin
      do_sync(VEC[i][0], VEC[i][1]);
      chk("R10 strobe", cval, 1);
      chk("R7 R6 pi corr", sc(corr), VEC[i][2]);
      @(negedge clk);
      chk("R10 one cycle", cval, 0);
      chk("R10 corr held", sc(corr), VEC[i][2]);
    end
    // R9
    relay = 1'b1;
    do_sync(10000, 10000); chk("R9 positive", sc(corr), 410);
    do_sync(10000, 11000); chk("R9 negative", sc(corr), -410);
    do_sync(10000, 10650); chk("R9 zero", sc(corr), 0);
    relay = 1'b0;
    do_sync(10000, 10650); chk("R9 integrator held", sc(corr), -40960);
    // R11 P = 2.5
    kp = 16'h2800;
    do_sync(0, 648); chk("R11 p2.5", sc(corr), -12288);
    kp = 16'h1000;
    // R4 restart with concurrent sync
    @(negedge clk); mreq = 1'b1; sval = 1'b1; mt = 0; lt = 0;
    @(negedge clk); mreq = 1'b0; sval = 1'b0;
    chk("R4 no strobe", cval, 0); chk("R4 lock dropped", lock, 0);
    chk("R4 delay kept", dly, 650);
    do_sync(0, 0); chk("R5 unlocked after restart", cval, 0);
    do_meas(1000, 1700, 2600, 3200);
    chk("R4 relocked", lock, 1);
    kp = 16'h0000; ki = 16'h0001;
    do_sync(0, 650); chk("R4 integrator cleared", sc(corr), 0);
    // R7 R8 saturation
    kp = 16'h1000; ki = 16'h1000;
    do_sync(64'h4000_0000_0000_0000, 0); chk("R7 corr sat", sc(corr), CMAX);
    kp = 16'h0000; ki = 16'h0001;
    do_sync(0, 650); chk("R8 acc at max", sc(corr), CMAX);
    do_sync(100, 745); chk("R8 no wrap", sc(corr), CMAX);
    do_sync(0, 64'h4000_0000_0000_0000); chk("R8 acc at min", sc(corr), CMIN);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule